// File: doc/BRIEF.md
# Cascadable Magnitude Comparator with Held P Operand

This block decides whether an operand P is greater than, less than or equal to an operand Q. Both operands are WIDTH bits wide, 8 by default. A mode input chooses how the bits are read. High means plain unsigned magnitude. Low means two's-complement signed. The P operand passes through a hold stage. While the load enable is high, the live P input is used directly. While the enable is low, the stage keeps supplying the P word it captured at the last rising clock edge on which the enable was high. A new P can therefore be frozen while Q is swept. A synchronous reset clears the held word to zero.

A strict inequality drives the two decision outputs directly. When the words are equal, the stage copies two incoming cascade decisions to its outputs. Stages chain into wider comparators. The outputs of the stage holding the less significant bits feed the cascade inputs of the next stage up. The lowest stage ties its cascade inputs low, and only the top stage of a chain may use signed mode. From the effective P, Q, mode and cascade inputs to the outputs, the path is purely combinational.

Top module: `latched_mag_comparator`

## Requirements
- R1: With `cmp_unsigned` = 1, if P > Q as unsigned numbers, `gt_out` = 1 and `lt_out` = 0. If P < Q, `gt_out` = 0 and `lt_out` = 1. This holds for any value of `gt_in` and `lt_in`.
- R2: With `cmp_unsigned` = 0, P and Q are read as two's-complement (bit WIDTH-1 is the sign). The same output rule as R1 applies to the signed order, for any cascade inputs.
- R3: If the effective P equals Q, `gt_out` equals `gt_in` and `lt_out` equals `lt_in`, in either mode.
- R4: While `p_load_en` = 1, the comparison uses the present `p_in` in the same cycle, with no clock edge needed.
- R5: While `p_load_en` = 0, the comparison uses the `p_in` value sampled at the most recent rising edge of `clk` at which `p_load_en` was 1. Changes on `p_in` have no effect on the outputs.
- R6: A rising edge of `clk` with `rst` = 1 clears the held P word to zero. The edge clears it whatever the load enable is.
- R7: Two stages form a 2*WIDTH-bit comparator. The low stage runs with `cmp_unsigned` = 1 and cascade inputs 0. Its outputs drive the cascade inputs of the high stage. The high stage's outputs then give the full-width compare in the high stage's mode, and both are 0 for equal words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held P word |
| rst | input | 1 | Synchronous active-high reset, clears the held P word |
| cmp_unsigned | input | 1 | 1 = unsigned compare, 0 = two's-complement compare |
| p_load_en | input | 1 | 1 = P passes through live and is captured each edge; 0 = held P is used |
| p_in | input | WIDTH | P operand |
| q_in | input | WIDTH | Q operand |
| gt_in | input | 1 | Greater decision from the less significant stage |
| lt_in | input | 1 | Less decision from the less significant stage |
| gt_out | output | 1 | This stage's P-greater decision |
| lt_out | output | 1 | This stage's P-less decision |

## Verification
Some rules are checked on every cycle. These are the unsigned and signed ordering, the equal-word pass-through and the mutual exclusion of the outputs, all while P passes live. Two more are also checked each cycle: outputs stay steady while P is held and every other input is steady, and a held word reads as zero just after reset. Other behaviour shows only in the bench scenarios. These scenarios sweep every operand pair in both modes with random cascade inputs. They capture a P word and then change the live input and Q. They also build a two-stage 16-bit chain and compare it against a behavioural model.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    MODE_SIGNED   = 1'b0,
    MODE_UNSIGNED = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    logic gt;
    logic lt;
  } verdict_t;
endpackage

// File: rtl/p_hold.sv
module p_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_eff
);
  logic [WIDTH-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (load_en) held <= d;
  end

  // Pass-through while loading, stored word otherwise
  assign q_eff = load_en ? d : held;
endmodule

// File: rtl/mag_core.sv
module mag_core
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  cmp_mode_e        mode,
  output verdict_t         res
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] a_ord, b_ord;
  logic [WIDTH-1:0] bit_gt, bit_lt;

  // Inverting the sign bit maps signed order onto unsigned order
  always_comb begin
    a_ord = a;
    b_ord = b;
    if (mode == MODE_SIGNED) begin
      a_ord[MSB] = ~a[MSB];
      b_ord[MSB] = ~b[MSB];
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_gt[i] = a_ord[i] & ~b_ord[i];
    assign bit_lt[i] = ~a_ord[i] & b_ord[i];
  end

  // First differing bit from the top decides
  always_comb begin
    logic decided;
    decided = 1'b0;
    res     = '0;
    for (int i = MSB; i >= 0; i--) begin
      if (!decided && (bit_gt[i] || bit_lt[i])) begin
        res.gt  = bit_gt[i];
        res.lt  = bit_lt[i];
        decided = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cascade_merge.sv
module cascade_merge
  import cmp_pkg::*;
(
  input  verdict_t local_v,
  input  verdict_t carry_v,
  output verdict_t out_v
);
  // A strict local decision wins; equality defers to the lower stage
  assign out_v = (local_v.gt || local_v.lt) ? local_v : carry_v;
endmodule

// File: rtl/latched_mag_comparator.sv
module latched_mag_comparator
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_unsigned,
  input  logic             p_load_en,
  input  logic [WIDTH-1:0] p_in,
  input  logic [WIDTH-1:0] q_in,
  input  logic             gt_in,
  input  logic             lt_in,
  output logic             gt_out,
  output logic             lt_out
);
  logic [WIDTH-1:0] p_eff;
  cmp_mode_e        mode;
  verdict_t         local_v, carry_v, out_v;

  assign mode    = cmp_unsigned ? MODE_UNSIGNED : MODE_SIGNED;
  assign carry_v = '{gt: gt_in, lt: lt_in};

  p_hold #(.WIDTH(WIDTH)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_en(p_load_en),
    .d      (p_in),
    .q_eff  (p_eff)
  );

  mag_core #(.WIDTH(WIDTH)) u_core (
    .a   (p_eff),
    .b   (q_in),
    .mode(mode),
    .res (local_v)
  );

  cascade_merge u_merge (
    .local_v(local_v),
    .carry_v(carry_v),
    .out_v  (out_v)
  );

  assign gt_out = out_v.gt;
  assign lt_out = out_v.lt;
endmodule

// File: rtl/latched_mag_comparator_chk.sv
module latched_mag_comparator_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_unsigned,
  input logic             p_load_en,
  input logic [WIDTH-1:0] p_in,
  input logic [WIDTH-1:0] q_in,
  input logic             gt_in,
  input logic             lt_in,
  input logic             gt_out,
  input logic             lt_out
);
  p_unsigned_order_r1: assert property (@(posedge clk) disable iff (rst)
    (p_load_en && cmp_unsigned && p_in != q_in) |->
      (gt_out == (p_in > q_in)) && (lt_out == (p_in < q_in)));

  p_signed_order_r2: assert property (@(posedge clk) disable iff (rst)
    (p_load_en && !cmp_unsigned && p_in != q_in) |->
      (gt_out == ($signed(p_in) > $signed(q_in))) &&
      (lt_out == ($signed(p_in) < $signed(q_in))));

  p_equal_passes_r3: assert property (@(posedge clk) disable iff (rst)
    (p_load_en && p_in == q_in) |-> (gt_out == gt_in) && (lt_out == lt_in));

  p_outputs_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(gt_in && lt_in) |-> !(gt_out && lt_out));

  p_held_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (!p_load_en && $past(!p_load_en) && $past(!rst) && $stable(q_in) &&
     $stable(cmp_unsigned) && $stable(gt_in) && $stable(lt_in)) |->
      ($stable(gt_out) && $stable(lt_out)));

  p_reset_clears_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !p_load_en && q_in == '0) |->
      (gt_out == gt_in) && (lt_out == lt_in));
endmodule

bind latched_mag_comparator latched_mag_comparator_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmp_unsigned(cmp_unsigned),
  .p_load_en   (p_load_en),
  .p_in        (p_in),
  .q_in        (q_in),
  .gt_in       (gt_in),
  .lt_in       (lt_in),
  .gt_out      (gt_out),
  .lt_out      (lt_out)
);

// File: tb/latched_mag_comparator_tb_top.sv
module latched_mag_comparator_tb_top;
  localparam int W        = 8;
  localparam int CLK_HALF = 5;
  localparam int CLK_PER  = 2 * CLK_HALF;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_u = 1'b1, en = 1'b1, gi = 1'b0, li = 1'b0;
  logic [W-1:0] p = '0, q = '0;
  logic go, lo_o;

  // cascade pair
  logic hi_mode = 1'b1;
  logic [W-1:0] ph = '0, pl = '0, qh = '0, ql = '0;
  logic c_gt, c_lt, f_gt, f_lt;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int model_held = 0;

  always #CLK_HALF clk = ~clk;

  latched_mag_comparator #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .cmp_unsigned(mode_u), .p_load_en(en),
    .p_in(p), .q_in(q), .gt_in(gi), .lt_in(li), .gt_out(go), .lt_out(lo_o));

  latched_mag_comparator #(.WIDTH(W)) lo_i (
    .clk(clk), .rst(rst), .cmp_unsigned(1'b1), .p_load_en(1'b1),
    .p_in(pl), .q_in(ql), .gt_in(1'b0), .lt_in(1'b0), .gt_out(c_gt), .lt_out(c_lt));

  latched_mag_comparator #(.WIDTH(W)) hi_i (
    .clk(clk), .rst(rst), .cmp_unsigned(hi_mode), .p_load_en(1'b1),
    .p_in(ph), .q_in(qh), .gt_in(c_gt), .lt_in(c_lt), .gt_out(f_gt), .lt_out(f_lt));

  // Behavioural model of the held word
  always @(posedge clk) begin
    if (rst) model_held = 0;
    else if (en) model_held = int'(p);
  end

  function automatic int to_num(int v, int bits, bit uns);
    if (!uns && v >= (1 << (bits - 1))) return v - (1 << bits);
    return v;
  endfunction

  function automatic logic [1:0] expect_of(int pv, int qv, int bits, bit uns,
                                           logic cg, logic cl);
    int a = to_num(pv, bits, uns);
    int b = to_num(qv, bits, uns);
    if (a > b) return 2'b10;
    if (a < b) return 2'b01;
    return {cg, cl};
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got gt,lt=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(int pv, int qv, bit uns);
    if (pv == qv) return "R3";
    return uns ? "R1" : "R2";
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset with loading disabled: held word must read as zero (R6)
    en = 1'b0; p = 8'h5A; q = 8'h00; mode_u = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    gi = 1'b1; li = 1'b0; #1;
    check("R6 held zero vs Q=0", {go, lo_o}, 2'b10);
    q = 8'h01; #1;
    check("R6 held zero vs Q=1", {go, lo_o}, 2'b01);
    q = 8'hFF; mode_u = 1'b0; #1;
    check("R6 held zero vs Q=-1 signed", {go, lo_o}, 2'b10);

    // Exhaustive sweep, live P (R1 R2 R3 R4)
    en = 1'b1;
    for (int m = 0; m < 2; m++) begin
      mode_u = m[0];
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          logic [1:0] c;
          c = 2'($urandom_range(0, 2));
          p = a[W-1:0]; q = b[W-1:0]; gi = c[1]; li = c[0];
          #1;
          check(req_of(a, b, m[0]), {go, lo_o},
                expect_of(a, b, W, m[0], gi, li));
        end
      end
    end

    // Hold scenarios (R5), compare on every clock against model
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      en = 1'b1; p = W'($urandom);
      @(negedge clk);
      en = 1'b0;
      for (int k = 0; k < 6; k++) begin
        p = W'($urandom); q = W'($urandom);
        if (k == 0) q = W'(model_held);
        mode_u = k[0]; gi = k[1]; li = ~k[1];
        #1;
        check("R5 held P used", {go, lo_o},
              expect_of(model_held, int'(q), W, mode_u, gi, li));
        @(negedge clk);
      end
    end

    // Reset again while loading (R6)
    @(negedge clk);
    en = 1'b1; p = 8'h77; rst = 1'b1;
    @(negedge clk);
    en = 1'b0; rst = 1'b0; q = 8'h00; gi = 1'b0; li = 1'b1; mode_u = 1'b1; #1;
    check("R6 reset overrides load", {go, lo_o}, 2'b01);

    // Two-stage 16-bit chain (R7)
    for (int n = 0; n < 6000; n++) begin
      int a16, b16;
      hi_mode = n[0];
      a16 = int'($urandom_range(0, 65535));
      case (n % 4)
        0: b16 = a16;
        1: b16 = (a16 & 16'hFF00) | int'($urandom_range(0, 255));
        default: b16 = int'($urandom_range(0, 65535));
      endcase
      ph = a16[15:8]; pl = a16[7:0]; qh = b16[15:8]; ql = b16[7:0];
      #1;
      check("R7 16-bit chain", {f_gt, f_lt},
            expect_of(a16, b16, 16, hi_mode, 1'b0, 1'b0));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule